// File: doc/BRIEF.md
# Address Window Translation Unit

This block decides where a transaction goes. A lookup presents an address, a direction (outbound or inbound) and a flag that marks an interrupt-message write. The block compares the address against a set of programmable windows. One clock later it returns the translated address, the target id of the winning window, the index of that window, and an error pulse when nothing claims the access.

The outbound side has a default window at index 0 and a parameterised number of programmable windows above it. With checking switched off, an outbound address that no programmed window claims falls through to the default window. With checking switched on, the same access raises the error pulse instead. The inbound side has a parameterised number of general windows. It also has one extra window that only interrupt-message writes can use. That window has its own translation base and target id, so those writes can be steered to any port.

Each window holds a base, a size code, a translation base, a target id and an enable. A window is loaded whole through one write port. A second write strobe loads the outbound checking bit.

Top module: `awu_xlate`

## Requirements
- R1: After reset all windows hold zero with enables clear, checking is off, and `res_valid` and `res_err` are 0. An outbound lookup then translates through the default window with all fields zero, giving the address bits [11:0] of the input, target 0 and window 0.
- R2: A lookup with `lk_valid` high in cycle n gives `res_valid` high in cycle n+1 only. Each lookup produces exactly one result cycle.
- R3: Size code s covers 2^(12+s) bytes. An enabled window claims an address when the address bits at and above bit 12+s equal the same bits of the window base. Base bits below 12+s are ignored.
- R4: The translated address takes the translation-base bits at and above 12+s and the input address bits below 12+s. The target id is the winning window's.
- R5: When several enabled windows claim an address, the lowest index wins. This holds among outbound windows 1 to 4 and among inbound windows 0 to 2.
- R6: With checking off, an outbound address that no enabled programmed window claims uses window 0's size, translation base and target, whatever window 0's enable holds. It reports window 0 and no error.
- R7: With checking on, such an unclaimed outbound access gives `res_err` = 1 with address, target and window all 0. Claimed outbound accesses are unaffected.
- R8: An inbound lookup with `lk_msi` = 0 uses only inbound windows 0 to 2. It never uses the interrupt-message window. If none of them claims the address, it gives `res_err` = 1.
- R9: An inbound lookup with `lk_msi` = 1 uses only the interrupt-message window, which is inbound index 3. It reports window 3 with that window's translation and target, or `res_err` = 1 on a miss.
- R10: A window write with `cfg_idx` beyond the side's last window (above 4 outbound, above 3 inbound), or with `cfg_we` low, changes no window.
- R11: `res_err` is high only in a result cycle, for one cycle per failing lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_dir | input | 1 | Side written: 0 outbound, 1 inbound |
| cfg_idx | input | WIN_W (3) | Window index written |
| cfg_base | input | ADDR_W (32) | Window base |
| cfg_size | input | SZ_W (5) | Size code, 2^(12+code) bytes |
| cfg_xlat | input | ADDR_W (32) | Translation base |
| cfg_tgt | input | TGT_W (4) | Target id |
| cfg_en | input | 1 | Window enable |
| cfg_ctl_we | input | 1 | Strobe that loads the checking bit |
| cfg_chk_en | input | 1 | Outbound checking enable |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W (32) | Lookup address |
| lk_dir | input | 1 | Lookup side: 0 outbound, 1 inbound |
| lk_msi | input | 1 | Marks an interrupt-message write |
| res_valid | output | 1 | Result cycle |
| res_addr | output | ADDR_W (32) | Translated address |
| res_tgt | output | TGT_W (4) | Target id |
| res_win | output | WIN_W (3) | Winning window index |
| res_err | output | 1 | Unclaimed-access pulse |

## Verification
The assertions assume that `lk_dir` and `lk_msi` in the lookup cycle describe the result seen one cycle later. They also assume that a window write and a lookup that depends on it are never issued in the same cycle, because a write takes effect only from the next cycle. The stimulus drives every request as a single-cycle pulse on the falling edge. It keeps writes and lookups in separate cycles, and it uses size-aligned bases everywhere except one deliberately misaligned inbound window, which exercises the ignored low base bits.

// File: rtl/awu_pkg.sv
package awu_pkg;
   // smallest window is 2^MIN_SHIFT bytes
   localparam int MIN_SHIFT = 12;

   typedef enum logic {
      DIR_OUT = 1'b0,
      DIR_IN  = 1'b1
   } awu_dir_e;
endpackage

// File: rtl/awu_win_match.sv
module awu_win_match
   import awu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SZ_W   = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] xlat,
   input  logic [SZ_W-1:0]   size,
   input  logic              en,
   output logic              hit,
   output logic [ADDR_W-1:0] xaddr
);
   logic [ADDR_W-1:0] off_mask;

   always_comb begin
      for (int i = 0; i < ADDR_W; i++) begin
         off_mask[i] = (i < (MIN_SHIFT + int'(size)));
      end
      hit   = en && ((addr & ~off_mask) == (base & ~off_mask));
      xaddr = (xlat & ~off_mask) | (addr & off_mask);
   end
endmodule

// File: rtl/awu_win_bank.sv
module awu_win_bank #(
   parameter int N      = 4,
   parameter int IDX_W  = 3,
   parameter int ADDR_W = 32,
   parameter int SZ_W   = 5,
   parameter int TGT_W  = 4,
   parameter bit FORCE0 = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [SZ_W-1:0]   wr_size,
   input  logic [ADDR_W-1:0] wr_xlat,
   input  logic [TGT_W-1:0]  wr_tgt,
   input  logic              wr_enb,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic [N-1:0]      hit,
   output logic [ADDR_W-1:0] xaddr [N],
   output logic [TGT_W-1:0]  tgt   [N]
);
   for (genvar g = 0; g < N; g++) begin : g_win
      logic [ADDR_W-1:0] base_q, xlat_q;
      logic [SZ_W-1:0]   size_q;
      logic [TGT_W-1:0]  tgt_q;
      logic              en_q, en_eff;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= '0;
            xlat_q <= '0;
            size_q <= '0;
            tgt_q  <= '0;
            en_q   <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            base_q <= wr_base;
            xlat_q <= wr_xlat;
            size_q <= wr_size;
            tgt_q  <= wr_tgt;
            en_q   <= wr_enb;
         end
      end

      if (FORCE0 && (g == 0)) begin : g_dflt
         assign en_eff = 1'b1;
      end else begin : g_prog
         assign en_eff = en_q;
      end

      awu_win_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
         .addr (lk_addr),
         .base (base_q),
         .xlat (xlat_q),
         .size (size_q),
         .en   (en_eff),
         .hit  (hit[g]),
         .xaddr(xaddr[g])
      );
      assign tgt[g] = tgt_q;
   end
endmodule

// File: rtl/awu_prio_pick.sv
module awu_prio_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
      any = |req;
   end

   // R5: the chosen request is set and no lower one is
   always_comb begin
      if (any) begin
         a_r5_pick_lowest: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
      end
   end
endmodule

// File: rtl/awu_xlate.sv
module awu_xlate
   import awu_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int SZ_W         = 5,
   parameter int TGT_W        = 4,
   parameter int NUM_OUT_PROG = 4,
   parameter int NUM_IN_GEN   = 3,
   localparam int NUM_OUT = NUM_OUT_PROG + 1,
   localparam int NUM_IN  = NUM_IN_GEN + 1,
   localparam int MSI_IDX = NUM_IN_GEN,
   localparam int WIN_W   = $clog2((NUM_OUT > NUM_IN) ? NUM_OUT : NUM_IN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_dir,
   input  logic [WIN_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [SZ_W-1:0]   cfg_size,
   input  logic [ADDR_W-1:0] cfg_xlat,
   input  logic [TGT_W-1:0]  cfg_tgt,
   input  logic              cfg_en,
   input  logic              cfg_ctl_we,
   input  logic              cfg_chk_en,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_dir,
   input  logic              lk_msi,
   output logic              res_valid,
   output logic [ADDR_W-1:0] res_addr,
   output logic [TGT_W-1:0]  res_tgt,
   output logic [WIN_W-1:0]  res_win,
   output logic              res_err
);
   if (ADDR_W <= MIN_SHIFT) begin : g_bad_addr
      $error("ADDR_W must exceed the smallest window shift");
   end
   if (NUM_OUT_PROG < 1 || NUM_IN_GEN < 1) begin : g_bad_count
      $error("each side needs at least one programmable window");
   end
   if (TGT_W < 1 || SZ_W < 1) begin : g_bad_field
      $error("target and size fields need at least one bit");
   end

   logic                chk_q;
   logic [NUM_OUT-1:0]  ob_hit;
   logic [ADDR_W-1:0]   ob_xaddr [NUM_OUT];
   logic [TGT_W-1:0]    ob_tgt   [NUM_OUT];
   logic [NUM_IN-1:0]   ib_hit;
   logic [ADDR_W-1:0]   ib_xaddr [NUM_IN];
   logic [TGT_W-1:0]    ib_tgt   [NUM_IN];
   logic [WIN_W-1:0]    ob_pidx, ig_pidx, ob_sel;
   logic                ob_any, ig_any;
   logic [ADDR_W-1:0]   nx_addr;
   logic [TGT_W-1:0]    nx_tgt;
   logic [WIN_W-1:0]    nx_win;
   logic                nx_err;

   always_ff @(posedge clk) begin
      if (!rst_n)          chk_q <= 1'b0;
      else if (cfg_ctl_we) chk_q <= cfg_chk_en;
   end

   awu_win_bank #(.N(NUM_OUT), .IDX_W(WIN_W), .ADDR_W(ADDR_W), .SZ_W(SZ_W),
                  .TGT_W(TGT_W), .FORCE0(1'b1)) u_ob_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && (cfg_dir == DIR_OUT)), .wr_idx(cfg_idx),
      .wr_base(cfg_base), .wr_size(cfg_size), .wr_xlat(cfg_xlat),
      .wr_tgt(cfg_tgt), .wr_enb(cfg_en), .lk_addr(lk_addr),
      .hit(ob_hit), .xaddr(ob_xaddr), .tgt(ob_tgt)
   );

   awu_win_bank #(.N(NUM_IN), .IDX_W(WIN_W), .ADDR_W(ADDR_W), .SZ_W(SZ_W),
                  .TGT_W(TGT_W), .FORCE0(1'b0)) u_ib_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && (cfg_dir == DIR_IN)), .wr_idx(cfg_idx),
      .wr_base(cfg_base), .wr_size(cfg_size), .wr_xlat(cfg_xlat),
      .wr_tgt(cfg_tgt), .wr_enb(cfg_en), .lk_addr(lk_addr),
      .hit(ib_hit), .xaddr(ib_xaddr), .tgt(ib_tgt)
   );

   awu_prio_pick #(.N(NUM_OUT_PROG), .IDX_W(WIN_W)) u_ob_pick (
      .req(ob_hit[NUM_OUT-1:1]), .idx(ob_pidx), .any(ob_any)
   );

   awu_prio_pick #(.N(NUM_IN_GEN), .IDX_W(WIN_W)) u_ig_pick (
      .req(ib_hit[NUM_IN_GEN-1:0]), .idx(ig_pidx), .any(ig_any)
   );

   assign ob_sel = ob_pidx + WIN_W'(1);

   always_comb begin
      nx_addr = '0;
      nx_tgt  = '0;
      nx_win  = '0;
      nx_err  = 1'b0;
      if (lk_dir == DIR_OUT) begin
         if (ob_any) begin
            nx_addr = ob_xaddr[ob_sel];
            nx_tgt  = ob_tgt[ob_sel];
            nx_win  = ob_sel;
         end else if (chk_q) begin
            nx_err  = 1'b1;
         end else begin
            nx_addr = ob_xaddr[0];
            nx_tgt  = ob_tgt[0];
         end
      end else if (lk_msi) begin
         if (ib_hit[MSI_IDX]) begin
            nx_addr = ib_xaddr[MSI_IDX];
            nx_tgt  = ib_tgt[MSI_IDX];
            nx_win  = WIN_W'(MSI_IDX);
         end else begin
            nx_err  = 1'b1;
         end
      end else if (ig_any) begin
         nx_addr = ib_xaddr[ig_pidx];
         nx_tgt  = ib_tgt[ig_pidx];
         nx_win  = ig_pidx;
      end else begin
         nx_err = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_addr  <= '0;
         res_tgt   <= '0;
         res_win   <= '0;
         res_err   <= 1'b0;
      end else begin
         res_valid <= lk_valid;
         res_err   <= lk_valid && nx_err;
         if (lk_valid) begin
            res_addr <= nx_addr;
            res_tgt  <= nx_tgt;
            res_win  <= nx_win;
         end
      end
   end

   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);
   a_r2_result_single: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);
   a_r11_err_in_result: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> res_valid);
   a_r7_err_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> (res_addr == '0 && res_tgt == '0 && res_win == '0));
   a_r6_no_err_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_dir == DIR_OUT && !chk_q) |=> !res_err);
   a_r8_general_only: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_dir == DIR_IN && !lk_msi) |=>
         (res_err || res_win < WIN_W'(NUM_IN_GEN)));
   a_r9_msi_window: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_dir == DIR_IN && lk_msi) |=>
         (res_err || res_win == WIN_W'(MSI_IDX)));
endmodule

// File: tb/tb_awu_xlate.sv
module tb_awu_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0, cfg_dir = 0, cfg_en = 0, cfg_ctl_we = 0, cfg_chk_en = 0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_base = '0, cfg_xlat = '0;
   logic [4:0]  cfg_size = '0;
   logic [3:0]  cfg_tgt = '0;
   logic        lk_valid = 0, lk_dir = 0, lk_msi = 0;
   logic [31:0] lk_addr = '0;
   logic        res_valid, res_err;
   logic [31:0] res_addr;
   logic [3:0]  res_tgt;
   logic [2:0]  res_win;
   int          checks = 0, errors = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   awu_xlate dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
      .cfg_size(cfg_size), .cfg_xlat(cfg_xlat), .cfg_tgt(cfg_tgt), .cfg_en(cfg_en),
      .cfg_ctl_we(cfg_ctl_we), .cfg_chk_en(cfg_chk_en),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_dir(lk_dir), .lk_msi(lk_msi),
      .res_valid(res_valid), .res_addr(res_addr), .res_tgt(res_tgt),
      .res_win(res_win), .res_err(res_err)
   );

   typedef struct packed {
      logic        dir;
      logic        msi;
      logic [31:0] addr;
      logic        err;
      logic [2:0]  win;
      logic [3:0]  tgt;
      logic [31:0] xa;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 32'h1000_1234, 1'b0, 3'd1, 4'd2, 32'hA000_1234}, // R5 win1 over win2
      '{1'b0, 1'b0, 32'h1008_0010, 1'b0, 3'd2, 4'd3, 32'hB008_0010}, // R3 R4
      '{1'b0, 1'b0, 32'h2000_0FFC, 1'b0, 3'd3, 4'd4, 32'hC000_0FFC}, // R3 4KB top
      '{1'b0, 1'b0, 32'h2000_1000, 1'b0, 3'd0, 4'd1, 32'h8000_1000}, // R6 just past
      '{1'b0, 1'b0, 32'h3000_0004, 1'b0, 3'd0, 4'd1, 32'h8000_0004}, // R6 disabled win4
      '{1'b0, 1'b0, 32'h100F_FFFF, 1'b0, 3'd2, 4'd3, 32'hB00F_FFFF}, // R3 last byte
      '{1'b1, 1'b0, 32'h4000_0100, 1'b0, 3'd0, 4'd6, 32'h0010_0100}, // R5 inbound
      '{1'b1, 1'b0, 32'h4001_0000, 1'b0, 3'd1, 4'd7, 32'h0021_0000}, // R4
      '{1'b1, 1'b0, 32'h5000_1ABC, 1'b0, 3'd2, 4'd8, 32'h0030_0ABC}, // R3 base low bits
      '{1'b1, 1'b0, 32'h6000_0000, 1'b1, 3'd0, 4'd0, 32'h0000_0000}, // R8 miss
      '{1'b1, 1'b0, 32'hFEE0_0040, 1'b1, 3'd0, 4'd0, 32'h0000_0000}, // R8 no msi window
      '{1'b1, 1'b1, 32'hFEE0_0040, 1'b0, 3'd3, 4'd9, 32'h0FF0_0040}, // R9 hit
      '{1'b1, 1'b1, 32'h4000_0100, 1'b1, 3'd0, 4'd0, 32'h0000_0000}  // R9 only msi window
   };

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic write_win(input logic we, input logic d, input logic [2:0] idx,
                            input logic [31:0] base, input logic [4:0] sz,
                            input logic [31:0] xl, input logic [3:0] tg, input logic en);
      @(negedge clk);
      cfg_we = we; cfg_dir = d; cfg_idx = idx; cfg_base = base;
      cfg_size = sz; cfg_xlat = xl; cfg_tgt = tg; cfg_en = en;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic set_chk(input logic v);
      @(negedge clk);
      cfg_ctl_we = 1; cfg_chk_en = v;
      @(negedge clk);
      cfg_ctl_we = 0;
   endtask

   // result is registered at the edge between the two falling edges
   task automatic lookup(input logic d, input logic m, input logic [31:0] a);
      @(negedge clk);
      lk_valid = 1; lk_dir = d; lk_msi = m; lk_addr = a;
      @(negedge clk);
      lk_valid = 0;
   endtask

   task automatic expect_res(input string req, input logic err, input logic [2:0] win,
                             input logic [3:0] tg, input logic [31:0] xa);
      check(req, "valid", 64'(res_valid), 64'd1);
      check(req, "err", 64'(res_err), 64'(err));
      check(req, "win", 64'(res_win), 64'(win));
      check(req, "tgt", 64'(res_tgt), 64'(tg));
      check(req, "addr", 64'(res_addr), 64'(xa));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "valid after reset", 64'(res_valid), 64'd0);
      check("R1", "err after reset", 64'(res_err), 64'd0);
      rst_n = 1'b1;

      // R1 R6: unprogrammed default window passes low 12 bits only
      lookup(1'b0, 1'b0, 32'h1234_5678);
      expect_res("R1", 1'b0, 3'd0, 4'd0, 32'h0000_0678);
      @(negedge clk);
      check("R2", "single result cycle", 64'(res_valid), 64'd0);
      check("R11", "err drops", 64'(res_err), 64'd0);
      lookup(1'b1, 1'b0, 32'h1234_5678);
      expect_res("R8", 1'b1, 3'd0, 4'd0, 32'h0);
      @(negedge clk);
      check("R11", "err single pulse", 64'(res_err), 64'd0);

      // program windows
      write_win(1, 0, 3'd0, 32'h0,         5'd8,  32'h8000_0000, 4'd1, 1'b0);
      write_win(1, 0, 3'd1, 32'h1000_0000, 5'd4,  32'hA000_0000, 4'd2, 1'b1);
      write_win(1, 0, 3'd2, 32'h1000_0000, 5'd8,  32'hB000_0000, 4'd3, 1'b1);
      write_win(1, 0, 3'd3, 32'h2000_0000, 5'd0,  32'hC000_0000, 4'd4, 1'b1);
      write_win(1, 0, 3'd4, 32'h3000_0000, 5'd12, 32'hD000_0000, 4'd5, 1'b0);
      write_win(1, 1, 3'd0, 32'h4000_0000, 5'd4,  32'h0010_0000, 4'd6, 1'b1);
      write_win(1, 1, 3'd1, 32'h4000_0000, 5'd8,  32'h0020_0000, 4'd7, 1'b1);
      write_win(1, 1, 3'd2, 32'h5000_1234, 5'd0,  32'h0030_0000, 4'd8, 1'b1);
      write_win(1, 1, 3'd3, 32'hFEE0_0000, 5'd0,  32'h0FF0_0000, 4'd9, 1'b1);

      for (int k = 0; k < NV; k++) begin
         lookup(VECS[k].dir, VECS[k].msi, VECS[k].addr);
         expect_res($sformatf("R3/R4 vec%0d", k), VECS[k].err, VECS[k].win,
                    VECS[k].tgt, VECS[k].xa);
      end

      // R7: checking on
      set_chk(1'b1);
      lookup(1'b0, 1'b0, 32'h2000_1000);
      expect_res("R7", 1'b1, 3'd0, 4'd0, 32'h0);
      @(negedge clk);
      check("R11", "err after checked miss", 64'(res_err), 64'd0);
      lookup(1'b0, 1'b0, 32'h1000_1234);
      expect_res("R7", 1'b0, 3'd1, 4'd2, 32'hA000_1234);

      // R10: out-of-range and strobe-low writes change nothing
      write_win(1, 0, 3'd5, 32'h2000_1000, 5'd0, 32'hE000_0000, 4'd10, 1'b1);
      write_win(1, 0, 3'd7, 32'h2000_1000, 5'd0, 32'hE000_0000, 4'd10, 1'b1);
      lookup(1'b0, 1'b0, 32'h2000_1000);
      expect_res("R10", 1'b1, 3'd0, 4'd0, 32'h0);
      write_win(0, 0, 3'd4, 32'h3000_0000, 5'd12, 32'hD000_0000, 4'd5, 1'b1);
      lookup(1'b0, 1'b0, 32'h3000_0004);
      expect_res("R10", 1'b1, 3'd0, 4'd0, 32'h0);
      write_win(1, 1, 3'd4, 32'h6000_0000, 5'd0, 32'h0040_0000, 4'd11, 1'b1);
      lookup(1'b1, 1'b0, 32'h6000_0000);
      expect_res("R10", 1'b1, 3'd0, 4'd0, 32'h0);

      // R6: checking off again, default window returns
      set_chk(1'b0);
      lookup(1'b0, 1'b0, 32'h3000_0004);
      expect_res("R6", 1'b0, 3'd0, 4'd1, 32'h8000_0004);

      // R5: enable win4 (16MB) and confirm it wins over default
      write_win(1, 0, 3'd4, 32'h3000_0000, 5'd12, 32'hD000_0000, 4'd5, 1'b1);
      lookup(1'b0, 1'b0, 32'h30AB_CDEF);
      expect_res("R5", 1'b0, 3'd4, 4'd5, 32'hD0AB_CDEF);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule